// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic down-counter that gives an operating system its heartbeat. Software loads a 24-bit reload value and enables the counter. The counter then steps down once per tick. A tick is either every core clock cycle or each cycle on which an external reference tick-enable input is high, as software selects. When the count is zero and one more tick arrives, the counter expires. It sets a sticky flag, raises a one-cycle interrupt request if interrupts are enabled, and either restarts from the reload value or, when the reload value is zero, switches itself off.

Software reaches the timer through a simple synchronous register port: address, write enable, write data, read enable and registered read data. There are four registers: control/status at 0x10, reload at 0x14, current count at 0x18 and a read-only calibration constant at 0x1C. Reading control/status also clears the sticky flag. Writing any data to the current-count register restarts the count.

Control is a two-state machine. ST_OFF means not counting. ST_RUN means counting. There are three named transitions. T_START goes from ST_OFF to ST_RUN on a control write with bit 0 set. T_STOP goes from ST_RUN to ST_OFF on a control write with bit 0 clear. T_LAST goes from ST_RUN to ST_OFF on an expiry while the reload value is zero. Every other cycle keeps the state; in ST_RUN an expiry with a non-zero reload value restarts the count.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the timer is in ST_OFF, with all control bits, the flag and the reload value at zero. irq_o is low, rd_data_o is zero, and reads of control, reload and current return zero.
- R2: The control/status register holds enable at bit 0, interrupt enable at bit 1, tick source at bit 2 and the sticky flag at bit 16; all other bits read as zero. A write stores only bits 2:0 and never changes the flag. A cycle carrying a control write does not count.
- R3: A control/status read returns the state from before that access and clears the flag. If an expiry happens in the same cycle, the flag ends up set.
- R4: With tick source 1 the counter steps on every cycle. With tick source 0 it steps only on cycles where ref_tick_i is high. In ST_OFF it never steps.
- R5: An expiry is a tick that finds the count at zero. It sets the flag and, when interrupt enable is set, drives irq_o high for exactly one cycle, one cycle after the expiring edge. Flag and irq_o become visible together.
- R6: Entering ST_RUN (T_START) loads the count from the reload register, so the counter expires every reload+1 ticks.
- R7: An expiry while the reload value is zero takes T_LAST to ST_OFF, clearing enable. An expiry with a non-zero reload value restarts the count from the reload register.
- R8: A write of any data to the current register (0x18) loads the count from the reload register and clears the flag. It takes precedence over an expiry in the same cycle, which is then lost.
- R9: A read of the current register returns the count in ST_RUN and zero in ST_OFF.
- R10: A control write that keeps enable set but changes the tick source reloads the count at once.
- R11: Reads return data one cycle after the read strobe. Calibration (0x1C) reads 10000. Reload reads bits 23:0 with the upper bits zero. Unmapped addresses read zero, and writes to them or to calibration change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| ref_tick_i | input | 1 | Reference tick enable, used when tick source is 0 |
| irq_o | output | 1 | One-cycle expiry interrupt request |

## Verification
The counter is first run with the core clock source and small reload values, which shows the reload+1 period and the one-cycle interrupt spacing. It is then run from a sparse reference tick, which separates counting on every cycle from counting only on enabled cycles. Directed cases cover a zero reload (self-stop versus restart), writes to the current register mid-count, a tick-source change while running, and back-to-back control reads. Those reads expose whether the flag clears on read and whether an expiry in the same cycle survives. A long random mix of reads, writes and reference pulses is then compared, cycle by cycle, with a reference model in the bench.

// File: rtl/systick_pkg.sv
package systick_pkg;
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tick_state_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    localparam int OFF_CTRL  = 'h10;
    localparam int OFF_RLD   = 'h14;
    localparam int OFF_CUR   = 'h18;
    localparam int OFF_CALIB = 'h1C;
endpackage

// File: rtl/tick_core.sv
module tick_core
    import systick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_cur_i,
    input  logic             rd_ctrl_i,
    input  logic [2:0]       ctl_wdata_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             ref_tick_i,
    output logic             en_o,
    output logic             ie_o,
    output logic             src_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             ie_q, src_q, flag_q, flag_d, irq_q;
    logic             run, tick, quiet, expire, restart;

    assign run     = (state_q == ST_RUN);
    assign tick    = run && (src_q || ref_tick_i);
    assign quiet   = !wr_ctrl_i && !wr_cur_i;
    assign expire  = quiet && tick && (count_q == '0);
    assign restart = wr_ctrl_i && ctl_wdata_i[BIT_EN] &&
                     (!run || (ctl_wdata_i[BIT_SRC] != src_q));

    // next state: T_START, T_STOP, T_LAST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_ctrl_i && ctl_wdata_i[BIT_EN]) state_d = ST_RUN;
            ST_RUN: begin
                if (wr_ctrl_i && !ctl_wdata_i[BIT_EN]) state_d = ST_OFF;
                else if (expire && (reload_i == '0))   state_d = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        count_d = count_q;
        if (restart || wr_cur_i)  count_d = reload_i;
        else if (quiet && tick)   count_d = expire ? reload_i : count_q - 1'b1;
    end

    always_comb begin
        flag_d = flag_q;
        if (wr_cur_i)       flag_d = 1'b0;
        else if (expire)    flag_d = 1'b1;
        else if (rd_ctrl_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            flag_q  <= 1'b0;
            ie_q    <= 1'b0;
            src_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            flag_q  <= flag_d;
            if (wr_ctrl_i) begin
                ie_q  <= ctl_wdata_i[BIT_IE];
                src_q <= ctl_wdata_i[BIT_SRC];
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && ie_q;
    end

    assign en_o    = run;
    assign ie_o    = ie_q;
    assign src_o   = src_q;
    assign flag_o  = flag_q;
    assign count_o = count_q;
    assign irq_o   = irq_q;

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);
    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && quiet) |=> $stable(count_q));
    p_ref_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_q && !ref_tick_i && quiet) |=> ($stable(count_q) && state_q == ST_RUN));
    p_last_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_i == '0) |=> (state_q == ST_OFF));
    p_cur_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur_i |=> (!flag_q && count_q == $past(reload_i)));
endmodule

// File: rtl/tick_regfile.sv
module tick_regfile
    import systick_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic              en_i,
    input  logic              ie_i,
    input  logic              src_i,
    input  logic              flag_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              wr_ctrl_o,
    output logic              wr_cur_o,
    output logic              rd_ctrl_o
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_RLD   = ADDR_W'(OFF_RLD);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(OFF_CUR);
    localparam logic [ADDR_W-1:0] A_CALIB = ADDR_W'(OFF_CALIB);

    logic [CNT_W-1:0]  reload_q;
    logic [DATA_W-1:0] rdata_q, rview;
    logic              unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];
    assign wr_ctrl_o = we_i && (addr_i == A_CTRL);
    assign wr_cur_o  = we_i && (addr_i == A_CUR);
    assign rd_ctrl_o = re_i && (addr_i == A_CTRL);

    always_comb begin
        rview = '0;
        case (addr_i)
            A_CTRL: begin
                rview[BIT_EN]   = en_i;
                rview[BIT_IE]   = ie_i;
                rview[BIT_SRC]  = src_i;
                rview[BIT_FLAG] = flag_i;
            end
            A_RLD:   rview[CNT_W-1:0] = reload_q;
            A_CUR:   rview[CNT_W-1:0] = en_i ? count_i : '0;
            A_CALIB: rview = DATA_W'(CALIB_VAL);
            default: rview = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (we_i && addr_i == A_RLD) reload_q <= wdata_i[CNT_W-1:0];
            if (re_i)                    rdata_q  <= rview;
        end
    end

    assign reload_o = reload_q;
    assign rdata_o  = rdata_q;

    p_reload_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && addr_i == A_RLD) |=> (rdata_q[DATA_W-1:CNT_W] == '0));
    p_cur_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && addr_i == A_CUR && !en_i) |=> (rdata_q == '0));
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ref_tick_i,
    output logic              irq_o
);
    logic             en, ie, src, flag, wr_ctrl, wr_cur, rd_ctrl;
    logic [CNT_W-1:0] count, reload;

    tick_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .we_i(wr_en_i),
        .wdata_i(wr_data_i), .re_i(rd_en_i), .en_i(en), .ie_i(ie),
        .src_i(src), .flag_i(flag), .count_i(count), .rdata_o(rd_data_o),
        .reload_o(reload), .wr_ctrl_o(wr_ctrl), .wr_cur_o(wr_cur),
        .rd_ctrl_o(rd_ctrl)
    );

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_ctrl), .wr_cur_i(wr_cur),
        .rd_ctrl_i(rd_ctrl), .ctl_wdata_i(wr_data_i[2:0]), .reload_i(reload),
        .ref_tick_i(ref_tick_i), .en_o(en), .ie_o(ie), .src_o(src),
        .flag_o(flag), .count_o(count), .irq_o(irq_o)
    );
endmodule

// File: tb/tb_sys_tick_timer.sv
module tb_sys_tick_timer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0, ref_t = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    sys_tick_timer dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we),
        .wr_data_i(wd), .rd_en_i(re), .rd_data_o(rd),
        .ref_tick_i(ref_t), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // reference model state
    logic        m_en = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;
    logic [23:0] m_cnt = '0, m_rel = '0;
    logic [31:0] m_rd = '0;
    bit          m_rdv = 0;
    logic [7:0]  m_rda = '0;

    function automatic logic [31:0] view(input logic [7:0] a);
        logic [31:0] v = '0;
        case (a)
            8'h10: begin v[0] = m_en; v[1] = m_ie; v[2] = m_src; v[16] = m_flag; end
            8'h14: v[23:0] = m_rel;
            8'h18: v[23:0] = m_en ? m_cnt : 24'd0;
            8'h1C: v = 32'd10000;
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        logic tk, wc, wu, exp_e;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
            m_cnt = '0; m_rel = '0; m_rd = '0; m_rdv = 0;
        end else begin
            tk = m_en && (m_src || ref_t);
            wc = we && addr == 8'h10;
            wu = we && addr == 8'h18;
            exp_e = tk && !wc && !wu && m_cnt == 0;
            m_rdv = re;
            if (re) begin m_rd = view(addr); m_rda = addr; end
            m_irq = exp_e && m_ie;
            if (wu) m_flag = 0;
            else if (exp_e) m_flag = 1;
            else if (re && addr == 8'h10) m_flag = 0;
            if (wc) begin
                if (wd[0] && (!m_en || wd[2] != m_src)) m_cnt = m_rel;
                m_en = wd[0]; m_ie = wd[1]; m_src = wd[2];
            end else if (wu) begin
                m_cnt = m_rel;
            end else if (tk) begin
                if (m_cnt == 0) begin
                    m_cnt = m_rel;
                    if (m_rel == 0) m_en = 0;
                end else m_cnt = m_cnt - 1'b1;
            end
            if (we && addr == 8'h14) m_rel = wd[23:0];
        end
    end

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10: return "R3";
            8'h14: return "R11";
            8'h18: return "R9";
            8'h1C: return "R11";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // compare outputs at the falling edge, then drive the next cycle
    task automatic step(input logic [7:0] a, input bit w, input logic [31:0] d,
                        input bit r, input bit rt);
        @(negedge clk);
        check(irq === m_irq, "R5 irq", {31'd0, irq}, {31'd0, m_irq});
        if (m_rdv) check(rd === m_rd, tag_of(m_rda), rd, m_rd);
        addr = a; we = w; wd = d; re = r; ref_t = rt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int s;
        s = $urandom(32'h5eed);
        // R1 reset state
        repeat (3) @(negedge clk);
        check(irq === 1'b0, "R1 irq", {31'd0, irq}, 0);
        check(rd === 32'd0, "R1 rdata", rd, 0);
        rst_n = 1'b1;
        step(8'h10, 0, 0, 1, 0); step(8'h14, 0, 0, 1, 0);
        step(8'h18, 0, 0, 1, 0); step(8'h1C, 0, 0, 1, 0); // R11 calib
        step(8'h00, 0, 0, 1, 0); idle(1);
        // R6 period reload+1 with core clock, R5 pulse
        step(8'h14, 1, 32'd3, 0, 0);
        step(8'h10, 1, 32'h7, 0, 0);
        idle(13);
        // R3 read clears flag, second read sees it clear
        step(8'h10, 0, 0, 1, 0); step(8'h10, 0, 0, 1, 0); idle(2);
        // R4 reference tick source
        step(8'h10, 1, 32'h3, 0, 0);
        for (int i = 0; i < 30; i++) step(8'h18, 0, 0, 1, (i % 3) == 0);
        // R10 source change while enabled reloads
        step(8'h10, 1, 32'h7, 0, 0); step(8'h18, 0, 0, 1, 0); idle(2);
        // R8 current write mid-count
        step(8'h18, 1, 32'hDEAD, 0, 0); step(8'h10, 0, 0, 1, 0); idle(2);
        // R7 zero reload stops the timer
        step(8'h14, 1, 32'd0, 0, 0); step(8'h18, 1, 0, 0, 0);
        idle(3); step(8'h10, 0, 0, 1, 0); step(8'h18, 0, 0, 1, 0); idle(2);
        // R2 only low bits stored, flag untouched; R11 reload width, unmapped
        step(8'h10, 1, 32'hFFFF_FFF8, 0, 0); step(8'h10, 0, 0, 1, 0);
        step(8'h14, 1, 32'hFFFF_FFFF, 0, 0); step(8'h14, 0, 0, 1, 0);
        step(8'h1C, 1, 32'h1234, 0, 0); step(8'h1C, 0, 0, 1, 0);
        step(8'h44, 0, 0, 1, 0); idle(2);
        // random mix, all requirements against the model
        for (int i = 0; i < 6000; i++) begin
            int op;
            logic [7:0] ra;
            bit rt;
            op = $urandom_range(0, 11);
            rt = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 4))
                0: ra = 8'h10; 1: ra = 8'h14; 2: ra = 8'h18; 3: ra = 8'h1C;
                default: ra = 8'($urandom_range(0, 255));
            endcase
            case (op)
                0, 1, 2, 3: step(8'h00, 0, 0, 0, rt);
                4: step(ra, 0, 0, 1, rt);
                5: step(8'h10, 0, 0, 1, rt);
                6: step(8'h10, 1, {$urandom} | (($urandom_range(0, 3) != 0) ? 32'h1 : 32'h0), 0, rt);
                7: step(8'h14, 1, ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 6)), 0, rt);
                8: step(8'h18, 1, $urandom, $urandom_range(0, 1) == 1, rt);
                9: step(8'h18, 0, 0, 1, rt);
                default: step(ra, 0, 0, 1, rt);
            endcase
        end
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule